// File: doc/BRIEF.md
# Multi-digit zero-suppressing segment decoder

This block turns a row of 4-bit digit codes into active-low seven-segment words for a display of `NUM_DIGITS` digits. Each digit has its own decoder cell. A small ripple network joins the cells so that zeros at the high end, at the low end, or at both ends of the number are shown dark. A lamp-test control lights every segment. A brightness generator blanks the whole display for part of each 256-cycle frame. The lit fraction follows an 8-bit intensity value.

All inputs are plain control and data levels. They are sampled on every rising clock edge, and the registered segment words follow one cycle later. There is no handshake and no back-pressure. The output simply tracks the inputs.

Top module: `segzb_display`

## Requirements
- R1: Segment words are active low, with segment a on bit 0 up to segment g on bit 6 of each 7-bit digit word; digit i occupies bits 7i+6..7i. The lit sets for codes 0-9 are: 0 abcdef, 1 bc, 2 abdeg, 3 abcdg, 4 bcfg, 5 acdfg, 6 cdefg, 7 abc, 8 all, 9 abcfg.
- R2: Codes 10-14 light: 10 deg, 11 cdg, 12 bfg, 13 adfg, 14 defg. Code 15 lights nothing.
- R3: While the brightness enable is off, every segment of every digit is dark (all ones). This holds regardless of lamp test, mode or codes.
- R4: With `lamp_test_n` low and the brightness enable on, every segment is lit (all zeros). Lamp test also stops any zero suppression.
- R5: Mode 2'b01 (leading) blanks each zero digit that has only zero digits above it.
- R6: Mode 2'b10 (trailing) blanks each zero digit that has only zero digits below it.
- R7: Mode 2'b11 blanks a zero digit if either the leading rule or the trailing rule applies to it.
- R8: Mode 2'b00 blanks no digit, so a zero shows its glyph. Ripple blanking never affects a nonzero digit.
- R9: An 8-bit free-running counter turns the brightness enable on when the counter is below `intensity`. Intensity 0 keeps the display dark. Intensity N gives N lit cycles in every 256.
- R10: Outputs are registered. A change at the inputs appears after the next rising edge. A synchronous `rst` makes every segment dark and restarts the counter at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| codes | input | 4*NUM_DIGITS | Digit codes; digit 0 (least significant) in bits 3..0 |
| mode | input | 2 | Zero-suppression select: 00 none, 01 leading, 10 trailing, 11 both |
| lamp_test_n | input | 1 | Lamp test, active low |
| intensity | input | 8 | Brightness: lit cycles per 256 |
| seg_n | output | 7*NUM_DIGITS | Active-low segment words, digit 0 in bits 6..0 |

## Verification
The bench walks all sixteen codes with suppression off. This separates the glyph table from the ripple logic. One value with zeros at both ends and a nonzero core (0120) is run under all four modes, which shows that each chain runs in its own direction. All-zero, single-nonzero-at-one-end and interior-zero patterns (3040, 0A00) show where each chain stops and that interior zeros survive. Lamp test and blanking are then tried against each other and against suppression, and the lit cycles per frame are counted at several intensities, including 0 and 255.

// File: rtl/segzb_pkg.sv
package segzb_pkg;
  localparam int CODE_W = 4;
  localparam int SEG_W  = 7;

  typedef logic [SEG_W-1:0] seg_t;

  typedef enum logic [1:0] {
    SUP_NONE  = 2'b00,
    SUP_LEAD  = 2'b01,
    SUP_TRAIL = 2'b10,
    SUP_BOTH  = 2'b11
  } sup_mode_e;

  // Lit set per code, positive logic, bit 0 = segment a ... bit 6 = segment g.
  function automatic seg_t glyph_lit(input logic [CODE_W-1:0] code);
    seg_t s;
    case (code)
      4'd0:  s = 7'b0111111;
      4'd1:  s = 7'b0000110;
      4'd2:  s = 7'b1011011;
      4'd3:  s = 7'b1001111;
      4'd4:  s = 7'b1100110;
      4'd5:  s = 7'b1101101;
      4'd6:  s = 7'b1111100;
      4'd7:  s = 7'b0000111;
      4'd8:  s = 7'b1111111;
      4'd9:  s = 7'b1100111;
      4'd10: s = 7'b1011000;
      4'd11: s = 7'b1001100;
      4'd12: s = 7'b1100010;
      4'd13: s = 7'b1101001;
      4'd14: s = 7'b1111000;
      default: s = 7'b0000000;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/segzb_pwm.sv
module segzb_pwm #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] level,
  output logic             en
);
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= count_q + 1'b1;
  end

  assign en = (count_q < level);
endmodule

// File: rtl/segzb_ripple.sv
module segzb_ripple #(
  parameter int NUM_DIGITS = 4
) (
  input  logic [NUM_DIGITS-1:0] zero,
  input  logic                  lamp_n,
  input  logic [1:0]            mode,
  output logic [NUM_DIGITS-1:0] lead_in_n,
  output logic [NUM_DIGITS-1:0] trail_in_n
);
  import segzb_pkg::*;

  logic lead_on;
  logic trail_on;

  assign lead_on  = (mode == SUP_LEAD)  || (mode == SUP_BOTH);
  assign trail_on = (mode == SUP_TRAIL) || (mode == SUP_BOTH);

  // A stage passes a low blank request on only if it is zero itself
  // and lamp test is idle.
  always_comb begin
    logic [NUM_DIGITS-1:0] l;
    l = '1;
    l[NUM_DIGITS-1] = ~lead_on;
    for (int i = NUM_DIGITS - 2; i >= 0; i--) begin
      l[i] = l[i+1] | ~zero[i+1] | ~lamp_n;
    end
    lead_in_n = l;
  end

  always_comb begin
    logic [NUM_DIGITS-1:0] t;
    t = '1;
    t[0] = ~trail_on;
    for (int i = 1; i < NUM_DIGITS; i++) begin
      t[i] = t[i-1] | ~zero[i-1] | ~lamp_n;
    end
    trail_in_n = t;
  end
endmodule

// File: rtl/segzb_cell.sv
module segzb_cell
  import segzb_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              lamp_n,
  input  logic              blank_n,
  input  logic              lead_in_n,
  input  logic              trail_in_n,
  output seg_t              seg_n,
  output logic              zero
);
  logic ripple_hit;

  assign zero       = (code == '0);
  assign ripple_hit = zero && lamp_n && (!lead_in_n || !trail_in_n);

  // Priority: forced blank, then lamp test, then ripple blank, then glyph.
  always_comb begin
    if (!blank_n)        seg_n = '1;
    else if (!lamp_n)    seg_n = '0;
    else if (ripple_hit) seg_n = '1;
    else                 seg_n = ~glyph_lit(code);
  end
endmodule

// File: rtl/segzb_display.sv
module segzb_display #(
  parameter int NUM_DIGITS = 4,
  parameter int CNT_W      = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [segzb_pkg::CODE_W*NUM_DIGITS-1:0] codes,
  input  logic [1:0]                       mode,
  input  logic                             lamp_test_n,
  input  logic [CNT_W-1:0]                 intensity,
  output logic [segzb_pkg::SEG_W*NUM_DIGITS-1:0]  seg_n
);
  import segzb_pkg::*;

  localparam int WORD_W = SEG_W * NUM_DIGITS;

  logic                  pwm_en;
  logic [NUM_DIGITS-1:0] zero;
  logic [NUM_DIGITS-1:0] lead_in_n;
  logic [NUM_DIGITS-1:0] trail_in_n;
  logic [WORD_W-1:0]     seg_next;
  logic [WORD_W-1:0]     seg_q;

  segzb_pwm #(.CNT_W(CNT_W)) u_pwm (
    .clk   (clk),
    .rst   (rst),
    .level (intensity),
    .en    (pwm_en)
  );

  segzb_ripple #(.NUM_DIGITS(NUM_DIGITS)) u_ripple (
    .zero       (zero),
    .lamp_n     (lamp_test_n),
    .mode       (mode),
    .lead_in_n  (lead_in_n),
    .trail_in_n (trail_in_n)
  );

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    segzb_cell u_cell (
      .code       (codes[i*CODE_W +: CODE_W]),
      .lamp_n     (lamp_test_n),
      .blank_n    (pwm_en),
      .lead_in_n  (lead_in_n[i]),
      .trail_in_n (trail_in_n[i]),
      .seg_n      (seg_next[i*SEG_W +: SEG_W]),
      .zero       (zero[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) seg_q <= '1;
    else     seg_q <= seg_next;
  end

  assign seg_n = seg_q;
endmodule

// File: rtl/segzb_display_chk.sv
module segzb_display_chk #(
  parameter int NUM_DIGITS = 4,
  parameter int CNT_W      = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic [4*NUM_DIGITS-1:0]   codes,
  input logic [1:0]                mode,
  input logic                      lamp_test_n,
  input logic [CNT_W-1:0]          intensity,
  input logic [7*NUM_DIGITS-1:0]   seg_n,
  input logic                      pwm_en
);
  localparam int TOP_C = 4 * NUM_DIGITS - 1;
  localparam int TOP_S = 7 * NUM_DIGITS - 1;

  a_r3_blank_dark: assert property (@(posedge clk) disable iff (rst)
    !pwm_en |=> (seg_n == '1));

  a_r4_lamp_lit: assert property (@(posedge clk) disable iff (rst)
    (!lamp_test_n && pwm_en) |=> (seg_n == '0));

  a_r5_lead_top: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && lamp_test_n && pwm_en && codes[TOP_C -: 4] == 4'd0)
      |=> (seg_n[TOP_S -: 7] == 7'h7F));

  a_r6_trail_low: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && lamp_test_n && pwm_en && codes[3:0] == 4'd0)
      |=> (seg_n[6:0] == 7'h7F));

  a_r7_both_allzero: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11 && lamp_test_n && pwm_en && codes == '0)
      |=> (seg_n == '1));

  a_r8_zero_shown: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00 && lamp_test_n && pwm_en && codes[3:0] == 4'd0)
      |=> (seg_n[6:0] == 7'h40));

  a_r9_full_one_gap: assert property (@(posedge clk) disable iff (rst)
    (intensity == '1 && !pwm_en) |=> (pwm_en || intensity != '1));
endmodule

bind segzb_display segzb_display_chk #(
  .NUM_DIGITS (NUM_DIGITS),
  .CNT_W      (CNT_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .codes       (codes),
  .mode        (mode),
  .lamp_test_n (lamp_test_n),
  .intensity   (intensity),
  .seg_n       (seg_n),
  .pwm_en      (pwm_en)
);

// File: tb/segzb_display_tb.sv
module segzb_display_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ND = 4;
  localparam int NV = 19;

  // {codes[15:0], mode[1:0], lamp_n, blank mask[3:0]}
  localparam logic [22:0] VEC [NV] = '{
    {16'h0123, 2'b00, 1'b1, 4'h0},
    {16'h4567, 2'b00, 1'b1, 4'h0},
    {16'h89AB, 2'b00, 1'b1, 4'h0},
    {16'hCDEF, 2'b00, 1'b1, 4'h0},
    {16'h0120, 2'b00, 1'b1, 4'h0},
    {16'h0120, 2'b01, 1'b1, 4'h8},
    {16'h0120, 2'b10, 1'b1, 4'h1},
    {16'h0120, 2'b11, 1'b1, 4'h9},
    {16'h0000, 2'b01, 1'b1, 4'hF},
    {16'h0000, 2'b10, 1'b1, 4'hF},
    {16'h0000, 2'b00, 1'b1, 4'h0},
    {16'h1000, 2'b10, 1'b1, 4'h7},
    {16'h1000, 2'b01, 1'b1, 4'h0},
    {16'h0005, 2'b01, 1'b1, 4'hE},
    {16'h0A00, 2'b11, 1'b1, 4'hB},
    {16'h3040, 2'b11, 1'b1, 4'h1},
    {16'h0000, 2'b11, 1'b0, 4'h0},
    {16'h0F00, 2'b01, 1'b1, 4'h8},
    {16'h0005, 2'b10, 1'b1, 4'h0}
  };
  localparam string VTAG [NV] = '{
    "R1", "R1", "R2", "R2", "R8", "R5", "R6", "R7", "R5", "R6",
    "R8", "R6", "R5", "R5", "R7", "R7", "R4", "R5", "R8"
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] codes = '0;
  logic [1:0]  mode = 2'b00;
  logic        lamp_n = 1'b1;
  logic [7:0]  intensity = 8'hFF;
  logic [27:0] seg_n;
  logic [7:0]  mcnt;
  int total = 0;
  int bad = 0;

  segzb_display #(.NUM_DIGITS(ND), .CNT_W(8)) u_dut (
    .clk         (clk),
    .rst         (rst),
    .codes       (codes),
    .mode        (mode),
    .lamp_test_n (lamp_n),
    .intensity   (intensity),
    .seg_n       (seg_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Counter value the design uses at the next rising edge (R9).
  always @(posedge clk) begin
    if (rst) mcnt <= 8'd0;
    else     mcnt <= mcnt + 8'd1;
  end

  function automatic logic [6:0] glyph_n(input logic [3:0] c);
    case (c)
      4'd0: return 7'h40;  4'd1: return 7'h79;  4'd2: return 7'h24;
      4'd3: return 7'h30;  4'd4: return 7'h19;  4'd5: return 7'h12;
      4'd6: return 7'h03;  4'd7: return 7'h78;  4'd8: return 7'h00;
      4'd9: return 7'h18;  4'd10: return 7'h27; 4'd11: return 7'h33;
      4'd12: return 7'h1D; 4'd13: return 7'h16; 4'd14: return 7'h07;
      default: return 7'h7F;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input logic [22:0] v, input string tag);
    logic [3:0] mask;
    logic       lt;
    @(negedge clk);
    if (mcnt == 8'hFF) @(negedge clk);
    codes  = v[22:7];
    mode   = v[6:5];
    lamp_n = v[4];
    lt     = v[4];
    mask   = v[3:0];
    @(negedge clk);
    for (int d = 0; d < ND; d++) begin
      logic [6:0] e;
      e = mask[d] ? 7'h7F : (!lt ? 7'h00 : glyph_n(v[7+4*d +: 4]));
      check(tag, {25'd0, seg_n[7*d +: 7]}, {25'd0, e});
    end
  endtask

  task automatic duty(input logic [7:0] lvl);
    int lit;
    lit = 0;
    @(negedge clk);
    intensity = lvl; lamp_n = 1'b1; mode = 2'b00; codes = 16'h8888;
    repeat (256) begin
      @(negedge clk);
      if (seg_n !== 28'hFFFFFFF) lit++;
    end
    check("R9", lit, {24'd0, lvl});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    check("R10", {4'd0, seg_n}, {4'd0, 28'hFFFFFFF});
    rst = 1'b0;

    for (int k = 0; k < NV; k++) run_vec(VEC[k], VTAG[k]);

    // R10: one-cycle latency
    run_vec({16'h8888, 2'b00, 1'b1, 4'h0}, "R1");
    if (mcnt == 8'hFF || mcnt == 8'hFE) repeat (2) @(negedge clk);
    codes = 16'h1111;
    #(CLK_PERIOD/4);
    check("R10", {4'd0, seg_n}, {4'd0, 28'h0000000});
    @(negedge clk);
    check("R10", {4'd0, seg_n}, {4'd0, {4{7'h79}}});

    // R3: blanking beats lamp test
    @(negedge clk);
    intensity = 8'h00; lamp_n = 1'b0; codes = 16'h8888; mode = 2'b11;
    repeat (20) begin
      @(negedge clk);
      check("R3", {4'd0, seg_n}, {4'd0, 28'hFFFFFFF});
    end

    // R10 mid-run reset, then R4 lamp test beats suppression
    intensity = 8'hFF; codes = 16'h0000;
    rst = 1'b1;
    @(negedge clk);
    check("R10", {4'd0, seg_n}, {4'd0, 28'hFFFFFFF});
    rst = 1'b0;
    @(negedge clk);
    check("R4", {4'd0, seg_n}, {4'd0, 28'h0000000});

    // R9: duty cycle
    duty(8'd0);
    duty(8'd1);
    duty(8'd64);
    duty(8'd255);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule